// File: doc/BRIEF.md
# Strobed PCM Serial Timeslot Port

This block is a slave serial port that carries one 8-bit PCM sample in each direction per frame. The host marks the timeslot with an active-high strobe that repeats once per frame. While the strobe is high, the port takes serial receive bits from `ser_in` and sends transmit bits on `ser_out`. Both directions share the same strobe-defined slot. All logic runs directly from the externally supplied bit clock.

The codec core sees two parallel interfaces:

- **Transmit side.** The core offers a byte together with a flag saying whether that byte is a real sample. If the flag is low, the port sends an idle (quiet) code for the whole slot.
- **Receive side.** The port presents the captured byte with a one-clock valid pulse. The pulse comes inside the same slot the byte arrived in, so there is no frame of delay.

The serial output is modelled as a data and enable pair, and the pad tri-states whenever the enable is low.

A 3-bit rate code tells the port which bit clock the system uses. Only the rates fast enough to clock the port directly are served. The slower rates and the reserved codes leave the port idle.

Top module: `pcm_slot_port`

## Requirements
- R1: While the gated strobe is high, `ser_in` is sampled on each falling edge of `bclk`, most significant bit first. After the eighth sample, `rx_byte` holds the 8 sampled bits (first sample in bit 7). `rx_byte` changes at no other time.
- R2: `rx_valid` rises at the same falling edge that takes the eighth bit of a slot, stays high for exactly one `bclk` period, and pulses at most once per slot.
- R3: Bit clocks beyond the eighth while the strobe stays high are ignored. `rx_byte` keeps the slot's byte, no further `rx_valid` pulse occurs, and `ser_out` holds bit 0 of the transmitted byte.
- R4: If the strobe falls before eight bits are sampled, the partial byte is dropped: no `rx_valid` pulse, and `rx_byte` keeps its previous value. The next slot starts again at bit 7.
- R5: At the first rising edge of `bclk` with the gated strobe high, the transmit word is latched. Each rising edge of the slot then puts the next bit on `ser_out`, bit 7 first. Changes to `tx_byte` or `tx_valid` after that edge do not affect the slot.
- R6: If `tx_valid` is low at that first rising edge, the quiet code 8'hFF is sent for the whole slot instead of `tx_byte`.
- R7: `ser_oe` is low whenever `strobe` is low.
- R8: `rate_sel` codes 2, 3, 4 and 5 are the directly clocked rates (512, 1536, 2048, 4096 kHz), and the port is active only for these codes. Codes 0 and 1 (the slow rates) and codes 6 and 7 (reserved) keep `ser_oe` low and suppress all capture, so `rx_valid` stays low and `rx_byte` is unchanged.
- R9: While `rst_n` is low: `rx_byte` is 0, `rx_valid` is 0, and `ser_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; receive samples on falling edge, transmit changes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Bit-rate code; 2 to 5 enable the port |
| strobe | input | 1 | Active-high timeslot marker |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Output enable for the serial data pad (low means high impedance) |
| tx_byte | input | 8 | Transmit sample from the codec core |
| tx_valid | input | 1 | Transmit sample is real; low selects the quiet code |
| rx_byte | output | 8 | Last complete received sample |
| rx_valid | output | 1 | One-clock pulse when `rx_byte` is updated |

## Verification
Some internal faults show at the ports within one bit period:

- A bit counter that fails to clear between slots shifts every later slot, so the first `ser_out` bit of the next slot is already wrong.
- A wrongly held load decision shows as quiet code where data was due, or data where quiet code was due, on the first bit of that slot.

A receive counter that runs past eight, or that keeps a partial count across a short slot, shows within a slot as an extra or missing `rx_valid` pulse or a corrupted `rx_byte`. Slots that run long and slots that are cut short are both driven so that these errors surface.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    typedef enum logic [2:0] {
        RATE_128K  = 3'd0,
        RATE_256K  = 3'd1,
        RATE_512K  = 3'd2,
        RATE_1536K = 3'd3,
        RATE_2048K = 3'd4,
        RATE_4096K = 3'd5,
        RATE_RSV6  = 3'd6,
        RATE_RSV7  = 3'd7
    } rate_code_e;

    // Only rates fast enough to clock the port directly are served.
    function automatic logic rate_is_direct(input logic [2:0] code);
        case (rate_code_e'(code))
            RATE_512K, RATE_1536K, RATE_2048K, RATE_4096K: return 1'b1;
            default:                                       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pcm_rate_decode.sv
module pcm_rate_decode
    import pcm_slot_pkg::*;
#(
    parameter int unsigned RATE_W = 3
) (
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              strobe,
    output logic              slot_act
);
    logic direct_en;

    always_comb begin
        direct_en = rate_is_direct(3'(rate_sel));
        slot_act  = strobe & direct_en;
    end
endmodule

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              slot_act,
    input  logic              ser_in,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic              valid;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (!slot_act) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < FULL_CNT) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], ser_in};
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST_IDX) begin
                st_d.word  = {st_q.shreg[WORD_W-2:0], ser_in};
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_byte  = st_q.word;
    assign rx_valid = st_q.valid;

    AST_RX_VALID_PULSE: assert property (@(negedge bclk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2
    AST_RX_NO_VALID_IDLE: assert property (@(negedge bclk) disable iff (!rst_n)
        !slot_act |=> !rx_valid); // R4
    AST_RX_BYTE_ONLY_ON_VALID: assert property (@(negedge bclk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_valid); // R1
endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx #(
    parameter int unsigned       WORD_W = 8,
    parameter logic [WORD_W-1:0] QUIET  = {WORD_W{1'b1}}
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              slot_act,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              ser_out
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              sdo;
    } tx_state_t;

    tx_state_t         st_d, st_q;
    logic [WORD_W-1:0] load_word;

    always_comb begin
        st_d      = st_q;
        load_word = tx_valid ? tx_byte : QUIET;
        if (!slot_act) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == '0) begin
            st_d.sdo   = load_word[WORD_W-1];
            st_d.shreg = {load_word[WORD_W-2:0], 1'b0};
            st_d.cnt   = CNT_W'(1);
        end else if (st_q.cnt < FULL_CNT) begin
            st_d.sdo   = st_q.shreg[WORD_W-1];
            st_d.shreg = {st_q.shreg[WORD_W-2:0], 1'b0};
            st_d.cnt   = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{shreg: '0, cnt: '0, sdo: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.sdo;

    AST_TX_QUIET_FIRST: assert property (@(posedge bclk) disable iff (!rst_n)
        (slot_act && st_q.cnt == '0 && !tx_valid) |=> ser_out == QUIET[WORD_W-1]); // R6
    AST_TX_HOLD_AFTER_LAST: assert property (@(posedge bclk) disable iff (!rst_n)
        (slot_act && st_q.cnt == FULL_CNT) |=> $stable(ser_out)); // R3
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned RATE_W = 3
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              strobe,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_oe,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid
);
    logic slot_act;

    pcm_rate_decode #(.RATE_W(RATE_W)) i_rate (
        .rate_sel (rate_sel),
        .strobe   (strobe),
        .slot_act (slot_act)
    );

    pcm_slot_rx #(.WORD_W(WORD_W)) i_rx (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .slot_act (slot_act),
        .ser_in   (ser_in),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    pcm_slot_tx #(.WORD_W(WORD_W)) i_tx (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .slot_act (slot_act),
        .tx_byte  (tx_byte),
        .tx_valid (tx_valid),
        .ser_out  (ser_out)
    );

    assign ser_oe = slot_act;

    AST_OE_OFF_IDLE: assert property (@(posedge bclk) disable iff (!rst_n)
        !strobe |-> !ser_oe); // R7
    AST_SLOW_RATE_SILENT: assert property (@(negedge bclk) disable iff (!rst_n)
        (rate_sel < RATE_W'(2)) |=> !rx_valid); // R8
endmodule

// File: tb/test_pcm_slot_port.sv
`timescale 1ns/100ps
module test_pcm_slot_port;
    logic       bclk = 1'b0;
    logic       rst_n;
    logic [2:0] rate_sel;
    logic       strobe;
    logic       ser_in;
    logic       ser_out;
    logic       ser_oe;
    logic [7:0] tx_byte;
    logic       tx_valid;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    logic [7:0] rx_prev = 8'h00;

    always #2.5 bclk = ~bclk;

    pcm_slot_port i_pcm_slot_port (
        .bclk(bclk), .rst_n(rst_n), .rate_sel(rate_sel), .strobe(strobe),
        .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe),
        .tx_byte(tx_byte), .tx_valid(tx_valid),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    typedef struct packed {
        logic [7:0] rx;
        logic [7:0] tx;
        logic       txv;
        logic [3:0] len;
        logic [2:0] rate;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{8'h5A, 8'hC3, 1'b1, 4'd8,  3'd2},
        '{8'h81, 8'h7E, 1'b0, 4'd8,  3'd3},
        '{8'h96, 8'h01, 1'b1, 4'd11, 3'd4},
        '{8'h3F, 8'hA5, 1'b1, 4'd5,  3'd5},
        '{8'h12, 8'h34, 1'b1, 4'd8,  3'd0},
        '{8'hE7, 8'h5D, 1'b0, 4'd9,  3'd7},
        '{8'h6B, 8'h92, 1'b1, 4'd8,  3'd5},
        '{8'hFF, 8'h00, 1'b1, 4'd8,  3'd2}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge bclk);
        #1;
    endtask

    task automatic run_slot(input logic [7:0] rxw, input logic [7:0] txw,
                            input logic txv, input int len, input logic [2:0] rate);
        bit         en;
        logic [7:0] expw;
        bit         exp_v;
        en   = (rate >= 3'd2) && (rate <= 3'd5);
        expw = txv ? txw : 8'hFF;
        rate_sel = rate;
        tx_byte  = txw;
        tx_valid = txv;
        step();
        for (int i = 0; i <= len; i++) begin
            if (i >= 1 && en) begin
                int idx;
                idx = (i <= 8) ? 8 - i : 0;
                chk(ser_out == expw[idx], (i > 8) ? "R3" : (txv ? "R5" : "R6"),
                    "ser_out bit", int'(ser_out), int'(expw[idx]));
            end
            if (i >= 1)
                chk(ser_oe == en, en ? "R7" : "R8", "ser_oe in slot", int'(ser_oe), int'(en));
            exp_v = en && (i == 8);
            chk(rx_valid == exp_v, en ? "R2" : "R8", "rx_valid", int'(rx_valid), int'(exp_v));
            if (exp_v)
                chk(rx_byte == rxw, "R1", "rx_byte", int'(rx_byte), int'(rxw));
            if (i == len) begin
                strobe = 1'b0;
            end else begin
                strobe = 1'b1;
                ser_in = (i < 8) ? rxw[7 - i] : ~rxw[i % 8];
            end
            if (i == 1) begin
                tx_byte  = ~txw;
                tx_valid = ~txv;
            end
            step();
        end
        chk(ser_oe == 1'b0, "R7", "ser_oe after slot", int'(ser_oe), 0);
        chk(rx_valid == 1'b0, "R2", "rx_valid after slot", int'(rx_valid), 0);
        if (en && len >= 8) rx_prev = rxw;
        chk(rx_byte == rx_prev, (len < 8) ? "R4" : (en ? "R3" : "R8"),
            "rx_byte kept", int'(rx_byte), int'(rx_prev));
        step();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rate_sel = 3'd2; strobe = 1'b0; ser_in = 1'b0;
        tx_byte = 8'h00; tx_valid = 1'b0;
        #1;
        for (int k = 0; k < 3; k++) step();
        // R9: reset state
        chk(rx_valid == 1'b0, "R9", "rx_valid reset", int'(rx_valid), 0);
        chk(rx_byte == 8'h00, "R9", "rx_byte reset", int'(rx_byte), 0);
        chk(ser_out == 1'b1, "R9", "ser_out reset", int'(ser_out), 1);
        chk(ser_oe == 1'b0, "R7", "ser_oe reset", int'(ser_oe), 0);
        rst_n = 1'b1;
        step();

        for (int v = 0; v < 8; v++)
            run_slot(VECS[v].rx, VECS[v].tx, VECS[v].txv, int'(VECS[v].len), VECS[v].rate);

        // R4: one-bit slot, then short slot, then a full slot starts fresh
        run_slot(8'hC6, 8'h55, 1'b1, 1, 3'd2);
        run_slot(8'h0F, 8'hAA, 1'b0, 7, 3'd3);
        run_slot(8'hB4, 8'h69, 1'b1, 8, 3'd4);
        // R8: slow rate code 1, then recovery at 4096 kHz code
        run_slot(8'h77, 8'h88, 1'b1, 8, 3'd1);
        run_slot(8'h2D, 8'hD2, 1'b0, 10, 3'd5);
        // R6: quiet slot with all-zero transmit byte
        run_slot(8'h00, 8'h00, 1'b0, 8, 3'd2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule